// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose Pin Bank

This block is one bank of up to 32 general-purpose pins. Each pin can be driven from a stored output value or left as an input. A small register file, reached through single-cycle read and write strobes with a word address and 32-bit data, holds the direction and output state and reads back the synchronised pin levels.

Every pin has its own event detector. A detector is set either to edge mode (rising or falling) or to level mode (high or low). When its event occurs it latches a pending bit, and that bit stays set until software writes a one to the matching bit of the clear register. This applies to level events as well: a level event stays latched after the level has gone away. The bank combines the pending bits with a per-pin enable into one registered interrupt request. Software that wants an interrupt on both edges must flip the polarity itself.

Top module: `gpio_irq_bank`

## Requirements
- R1: After synchronous reset, every stored register is zero, so all pins are inputs with interrupts disabled. During reset `pin_out`, `pin_oe`, `irq` and `rdata` are zero.
- R2: The word addresses are 0 output value, 1 direction, 2 input level, 3 trigger mode, 4 polarity, 5 interrupt enable, 6 clear, and 7 pending. The data for a read appears on `rdata` one clock after `rd_en`. Registers 0, 1, 3, 4 and 5 read back the value last written to them.
- R3: `pin_out` follows the output-value register and `pin_oe` follows the direction register, where 1 means drive.
- R4: The input register returns each pin's level after a two-flop synchroniser, whatever the direction setting.
- R5: With trigger-mode bit 1 (edge) and polarity bit 1, a rising edge on the pin sets its pending bit and a falling edge does not.
- R6: With trigger-mode bit 1 and polarity bit 0, a falling edge sets the pending bit and a rising edge does not.
- R7: With trigger-mode bit 0 (level), the pin being at the polarity level sets the pending bit. The bit stays set after the level is removed, until it is cleared.
- R8: Writing 1 to a bit of the clear register clears that pending bit, and writing 0 leaves it unchanged. Reads of the clear register return zero.
- R9: When a clear and a new detection hit the same pin in the same cycle, the pending bit stays set.
- R10: Pending bits are set whatever the interrupt-enable setting, and the pending register reads them raw.
- R11: `irq` is registered. It equals the OR over all pins of (pending AND enable) as they stood one clock earlier.
- R12: When the bank is narrower than 32 pins, bits at and above the pin count read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 3 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| pin_in | input | NPINS | Raw pin levels |
| pin_out | output | NPINS | Output value for each pin |
| pin_oe | output | NPINS | Drive enable for each pin |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume that `wr_en` and `rd_en` are never X after reset. They also assume that the register file is written only through `wr_en`, so the direction bits and pending bits change only as a result of strobes or pin events. The stimulus changes pin levels and strobes only on falling clock edges. It holds every pin level for at least three clocks, so that each change passes through the synchroniser before it is checked. It also clears the pending bits that level mode latches straight after reset before it tests any detection.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_OUT  = 3'd0,
    REG_DIR  = 3'd1,
    REG_IN   = 3'd2,
    REG_MODE = 3'd3,
    REG_POL  = 3'd4,
    REG_IEN  = 3'd5,
    REG_CLR  = 3'd6,
    REG_PEND = 3'd7
  } gpio_reg_e;
endpackage

// File: rtl/gpio_sync.sv
// Two-flop synchroniser per pin, plus a one-cycle-delayed copy for edge compare.
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] raw,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      cur    <= '0;
      prev   <= '0;
    end else begin
      meta_q <= raw;
      cur    <= meta_q;
      prev   <= cur;
    end
  end
endmodule

// File: rtl/gpio_pin_detect.sv
// One pin's event detector and sticky pending bit; a detection beats a clear.
module gpio_pin_detect (
  input  logic clk,
  input  logic rst,
  input  logic cur,
  input  logic prev,
  input  logic edge_mode,
  input  logic pol,
  input  logic clr,
  output logic pend
);
  logic hit;

  always_comb begin
    if (edge_mode) hit = (cur != prev) && (cur == pol);
    else           hit = (cur == pol);
  end

  always_ff @(posedge clk) begin
    if (rst) pend <= 1'b0;
    else     pend <= hit | (pend & ~clr);
  end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic              irq
);
  localparam int PAD_W = DATA_W - NPINS;

  gpio_reg_e reg_sel;
  assign reg_sel = gpio_reg_e'(addr);

  logic [NPINS-1:0] out_q, dir_q, mode_q, pol_q, ien_q;
  logic [NPINS-1:0] sync_cur, sync_prev, pend_q, clr_vec;

  // Only the low NPINS bits of wdata are stored; the rest are dropped here.
  always_ff @(posedge clk) begin
    if (rst) begin
      out_q  <= '0;
      dir_q  <= '0;
      mode_q <= '0;
      pol_q  <= '0;
      ien_q  <= '0;
    end else if (wr_en) begin
      case (reg_sel)
        REG_OUT:  out_q  <= wdata[NPINS-1:0];
        REG_DIR:  dir_q  <= wdata[NPINS-1:0];
        REG_MODE: mode_q <= wdata[NPINS-1:0];
        REG_POL:  pol_q  <= wdata[NPINS-1:0];
        REG_IEN:  ien_q  <= wdata[NPINS-1:0];
        default: ;
      endcase
    end
  end

  assign clr_vec = (wr_en && reg_sel == REG_CLR) ? wdata[NPINS-1:0] : '0;

  gpio_sync #(.W(NPINS)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .raw  (pin_in),
    .cur  (sync_cur),
    .prev (sync_prev)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    gpio_pin_detect u_det (
      .clk       (clk),
      .rst       (rst),
      .cur       (sync_cur[i]),
      .prev      (sync_prev[i]),
      .edge_mode (mode_q[i]),
      .pol       (pol_q[i]),
      .clr       (clr_vec[i]),
      .pend      (pend_q[i])
    );
  end

  logic [NPINS-1:0] rd_sel;
  always_comb begin
    case (reg_sel)
      REG_OUT:  rd_sel = out_q;
      REG_DIR:  rd_sel = dir_q;
      REG_IN:   rd_sel = sync_cur;
      REG_MODE: rd_sel = mode_q;
      REG_POL:  rd_sel = pol_q;
      REG_IEN:  rd_sel = ien_q;
      REG_PEND: rd_sel = pend_q;
      default:  rd_sel = '0;
    endcase
  end

  logic [DATA_W-1:0] rd_word;
  if (PAD_W > 0) begin : g_pad
    assign rd_word = {{PAD_W{1'b0}}, rd_sel};
  end else begin : g_full
    assign rd_word = rd_sel;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      irq   <= 1'b0;
    end else begin
      if (rd_en) rdata <= rd_word;
      irq <= |(pend_q & ien_q);
    end
  end

  assign pin_out = out_q;
  assign pin_oe  = dir_q;
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int NPINS = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic [NPINS-1:0]  pin_oe,
  input logic              irq,
  input logic [NPINS-1:0]  pending,
  input logic [NPINS-1:0]  irq_en
);
  localparam logic [DATA_W-1:0] PIN_MASK =
    (NPINS >= DATA_W) ? '1 : ((DATA_W'(1) << NPINS) - 1'b1);

  logic [NPINS-1:0] clr_req;
  assign clr_req = (wr_en && addr == REG_CLR) ? wdata[NPINS-1:0] : '0;

  // R8: a pending bit only falls when a clear write named it
  p_sticky_pending_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((($past(pending) & ~$past(clr_req)) & ~pending) == '0));

  // R11: request follows pending AND enable one clock later
  p_irq_tracks_r11: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == $past(|(pending & irq_en))));

  // R11: no enabled bit means no request on the next cycle
  p_irq_masked_r11: assert property (@(posedge clk) disable iff (rst)
    (irq_en == '0) |=> !irq);

  // R3: drive enables move only on a direction write
  p_dir_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && addr == REG_DIR) |=> $stable(pin_oe));

  // R12: bits beyond the pin count never read as one
  p_upper_zero_r12: assert property (@(posedge clk) disable iff (rst)
    ((rdata & ~PIN_MASK) == '0));
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NPINS(NPINS)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .addr    (addr),
  .wdata   (wdata),
  .rdata   (rdata),
  .pin_oe  (pin_oe),
  .irq     (irq),
  .pending (pend_q),
  .irq_en  (ien_q)
);

// File: tb/gpio_irq_bank_tb.sv
`timescale 1ns/1ps
module gpio_irq_bank_tb;
  localparam int NP = 27;
  localparam logic [31:0] MASK = (32'd1 << NP) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NP-1:0] pin_in = '1;
  logic [NP-1:0] pin_out, pin_oe;
  logic irq;
  int total = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gpio_irq_bank #(.NPINS(NP)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq(irq)
  );

  // vector: {addr, write data, expected read-back}
  localparam int NV = 7;
  localparam logic [66:0] VEC [NV] = '{
    {3'd0, 32'hFFFF_FFFF, 32'h07FF_FFFF},
    {3'd0, 32'hA5A5_1234, 32'h05A5_1234},
    {3'd1, 32'h0F0F_00FF, 32'h070F_00FF},
    {3'd5, 32'hF800_0000, 32'h0000_0000},
    {3'd3, 32'h1234_5678, 32'h0234_5678},
    {3'd4, 32'hFFFF_0000, 32'h07FF_0000},
    {3'd6, 32'hFFFF_FFFF, 32'h0000_0000}
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 pin_oe", {5'd0, pin_oe}, 32'd0);
    check("R1 pin_out", {5'd0, pin_out}, 32'd0);
    check("R1 rdata", rdata, 32'd0);
    rst = 1'b0;
    rd(3'd5, v); check("R1 enable reset", v, 32'd0);
    rd(3'd3, v); check("R1 mode reset", v, 32'd0);

    // register read-back walk (R2, R8 clear reads zero, R12 upper bits)
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][66:64], VEC[i][63:32]);
      rd(VEC[i][66:64], v);
      check("R2/R12 readback", v, VEC[i][31:0]);
    end
    check("R3 pin_out", {5'd0, pin_out}, 32'h05A5_1234);
    check("R3 pin_oe", {5'd0, pin_oe}, 32'h070F_00FF);

    // R4: input register, independent of direction
    pin_in = 27'h2A5_5A5A; idle(4);
    rd(3'd2, v); check("R4 input", v, 32'h02A5_5A5A);
    pin_in = '1; idle(4);
    rd(3'd2, v); check("R4 input high", v, MASK);

    // setup: all edge, rising; clear stale level latches
    wr(3'd5, 32'd0);
    wr(3'd4, 32'hFFFF_FFFF);
    wr(3'd3, 32'hFFFF_FFFF);
    wr(3'd6, 32'hFFFF_FFFF);
    rd(3'd7, v); check("R8 clear all", v, 32'd0);

    // R5: rising edge mode on pin 3
    pin_in[3] = 1'b0; idle(5);
    rd(3'd7, v); check("R5 falling ignored", v, 32'd0);
    pin_in[3] = 1'b1; idle(5);
    rd(3'd7, v); check("R5 rising latched", v, 32'h8);
    // R10: pending with enable off, request stays low
    check("R10 no irq when disabled", {31'd0, irq}, 32'd0);
    // R11: request one clock after enable lands
    wr(3'd5, 32'h8);
    check("R11 irq not yet", {31'd0, irq}, 32'd0);
    @(negedge clk);
    check("R11 irq raised", {31'd0, irq}, 32'd1);
    wr(3'd6, 32'h0);
    rd(3'd7, v); check("R8 write zero no effect", v, 32'h8);
    wr(3'd6, 32'h8);
    check("R11 irq still one", {31'd0, irq}, 32'd1);
    @(negedge clk);
    check("R11 irq dropped", {31'd0, irq}, 32'd0);
    rd(3'd7, v); check("R8 cleared", v, 32'd0);

    // R6: falling edge mode on pin 5
    wr(3'd4, 32'hFFFF_FFDF);
    pin_in[5] = 1'b0; idle(5);
    rd(3'd7, v); check("R6 falling latched", v, 32'h20);
    wr(3'd6, 32'h20);
    pin_in[5] = 1'b1; idle(5);
    rd(3'd7, v); check("R6 rising ignored", v, 32'd0);

    // R7: level-high mode on pin 7, short pulse
    pin_in[7] = 1'b0; idle(5);
    wr(3'd6, 32'hFFFF_FFFF);
    wr(3'd3, 32'hFFFF_FF7F);
    idle(3);
    rd(3'd7, v); check("R7 inactive level", v, 32'd0);
    pin_in[7] = 1'b1; idle(3);
    pin_in[7] = 1'b0; idle(5);
    rd(3'd7, v); check("R7 level latched", v, 32'h80);
    wr(3'd6, 32'h80);
    rd(3'd7, v); check("R7 cleared after level gone", v, 32'd0);

    // R9: clear while level still active, detection wins
    pin_in[7] = 1'b1; idle(5);
    wr(3'd6, 32'h80);
    rd(3'd7, v); check("R9 set beats clear", v, 32'h80);
    pin_in[7] = 1'b0; idle(5);
    wr(3'd6, 32'h80);
    rd(3'd7, v); check("R9 clears once level gone", v, 32'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule